// File: doc/BRIEF.md
# Event Flag Interrupt Collector

This block gathers single-cycle pulses from three timekeeping event sources: an alarm match, a periodic tick and an end-of-update marker. Each pulse sets a sticky flag. The flag image, with a summary bit on top, is what a host sees when it reads the status register. Each flag has an enable bit, and only a set flag whose enable is also set pulls the interrupt request line low.

The request line is open-drain. The block never drives it high. It only tells the pad whether to pull low (`irq_drive_low` = 1) or to float (`irq_drive_low` = 0). There is no acknowledge write. Reading the status register is the acknowledge: the read sees the flags as they stood, and the clock edge that ends the read cycle clears them and so releases the line. A pulse that lands in the read cycle survives the clear. A synchronous reset also clears every flag and releases the line.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While `rst` is high, every clock edge clears all flags and the summary bit and sets `irq_drive_low` to 0 (line floating), even with event pulses present.
- R2: A pulse on `evt_pulse[i]` sets status bit `i` at the next clock edge, whatever the value of `evt_en[i]`. The bit positions are alarm = 0, periodic = 1 and update-ended = 2.
- R3: After each clock edge, `irq_drive_low` is 1 exactly when some status bit `i` is set and `evt_en[i]` was 1 before that edge. It is 0 otherwise, and 0 means the line is released, never driven high.
- R4: A set flag stays set across edges where `stat_rd` is 0.
- R5: During a cycle with `stat_rd` high, `stat_q` still shows the pre-read flags. After that edge, flags without a new pulse are clear and, if no enabled pulse arrived, `irq_drive_low` is 0.
- R6: A pulse in the same cycle as a status read leaves its flag set after the clearing edge.
- R7: Bit `NUM_EVT` of `stat_q` (bit 3 at the default) is the summary bit. It equals `irq_drive_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_EVT | One-cycle event pulses, one per source |
| evt_en | input | NUM_EVT | Per-source interrupt enable |
| stat_rd | input | 1 | High for the cycle in which the status register is read |
| stat_q | output | NUM_EVT+1 | Status image: flags in the low bits, summary at the top |
| irq_drive_low | output | 1 | 1 pulls the open-drain request line low, 0 leaves it floating |

## Verification
The bench builds the block with the default `NUM_EVT` = 3. At that size every flag can be driven by its own pulse pattern, and the bench can cover pulses with the enable off and then switched on later. It also covers enables that mask only some of the set flags, a read with no pulse pending, and a read that collides with a new pulse. Reset is also applied while every pulse and enable is active, which shows that reset wins over a pulse arriving at the same edge.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
  // Flag positions inside the status image; the host decodes these.
  localparam int EVT_ALARM    = 0;
  localparam int EVT_PERIODIC = 1;
  localparam int EVT_UPDATE   = 2;
  localparam int EVT_COUNT    = 3;
endpackage

// File: rtl/evt_flag_bank.sv
`timescale 1ns/1ps
module evt_flag_bank #(
  parameter int NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               stat_rd,
  output logic [NUM_EVT-1:0] flag_d,
  output logic [NUM_EVT-1:0] flag_q
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    // A new pulse wins over the read clear, so a colliding event is kept.
    always_comb flag_d[g] = evt_pulse[g] | (flag_q[g] & ~stat_rd);

    always_ff @(posedge clk) begin
      if (rst) flag_q[g] <= 1'b0;
      else     flag_q[g] <= flag_d[g];
    end
  end
endmodule

// File: rtl/irq_summary.sv
`timescale 1ns/1ps
module irq_summary #(
  parameter int NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] flag_d,
  input  logic [NUM_EVT-1:0] evt_en,
  output logic               sum_q
);
  logic sum_d;

  // Built from the next flag state, so it changes on the same edge as the flags.
  always_comb sum_d = |(flag_d & evt_en);

  always_ff @(posedge clk) begin
    if (rst) sum_q <= 1'b0;
    else     sum_q <= sum_d;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
`timescale 1ns/1ps
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT = EVT_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EVT-1:0] evt_en,
  input  logic               stat_rd,
  output logic [NUM_EVT:0]   stat_q,
  output logic               irq_drive_low
);
  localparam int SUM_BIT = NUM_EVT;

  logic [NUM_EVT-1:0] flag_d;
  logic [NUM_EVT-1:0] flag_q;
  logic               sum_q;

  evt_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .stat_rd   (stat_rd),
    .flag_d    (flag_d),
    .flag_q    (flag_q)
  );

  irq_summary #(.NUM_EVT(NUM_EVT)) u_sum (
    .clk    (clk),
    .rst    (rst),
    .flag_d (flag_d),
    .evt_en (evt_en),
    .sum_q  (sum_q)
  );

  always_comb begin
    stat_q               = '0;
    stat_q[NUM_EVT-1:0]  = flag_q;
    stat_q[SUM_BIT]      = sum_q;
  end

  // The pad is open-drain: this only requests a pull-down.
  assign irq_drive_low = sum_q;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
`timescale 1ns/1ps
module evt_irq_ctrl_chk #(
  parameter int NUM_EVT = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic [NUM_EVT-1:0] evt_en,
  input logic               stat_rd,
  input logic [NUM_EVT:0]   stat_q,
  input logic               irq_drive_low
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && !irq_drive_low));

  p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
    (|evt_pulse) |=> ((stat_q[NUM_EVT-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_drive_low == |(stat_q[NUM_EVT-1:0] & $past(evt_en))));

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> ((stat_q[NUM_EVT-1:0] & $past(stat_q[NUM_EVT-1:0]))
                  == $past(stat_q[NUM_EVT-1:0])));

  p_read_release_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(|evt_pulse)) |=> (stat_q == '0 && !irq_drive_low));

  p_read_keep_r6: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (stat_q[NUM_EVT-1:0] == $past(evt_pulse)));

  p_summary_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (stat_q[NUM_EVT] == irq_drive_low));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .evt_pulse     (evt_pulse),
  .evt_en        (evt_en),
  .stat_rd       (stat_rd),
  .stat_q        (stat_q),
  .irq_drive_low (irq_drive_low)
);

// File: tb/test_evt_irq_ctrl.sv
`timescale 1ns/1ps
module test_evt_irq_ctrl;
  localparam int N  = 3;
  localparam int NV = 11;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] evt_pulse;
  logic [N-1:0] evt_en;
  logic         stat_rd;
  logic [N:0]   stat_q;
  logic         irq_drive_low;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  evt_irq_ctrl #(.NUM_EVT(N)) i_evt_irq_ctrl (
    .clk           (clk),
    .rst           (rst),
    .evt_pulse     (evt_pulse),
    .evt_en        (evt_en),
    .stat_rd       (stat_rd),
    .stat_q        (stat_q),
    .irq_drive_low (irq_drive_low)
  );

  // {pulse[2:0], en[2:0], rd, expected stat_q[3:0] after the edge}
  localparam logic [10:0] VEC [NV] = '{
    11'b001_000_0_0001,  // R2 flag set while disabled
    11'b000_001_0_1001,  // R3 enable turned on later
    11'b010_001_0_1011,  // R2 second flag, R4 first held
    11'b000_000_0_0011,  // R3 enables dropped, line released
    11'b000_110_0_1011,  // R3 partial mask
    11'b000_110_1_0000,  // R5 read clears
    11'b100_100_1_1100,  // R6 pulse during read kept
    11'b000_100_0_1100,  // R4 hold
    11'b000_100_1_0000,  // R5 read clears
    11'b111_000_0_0111,  // R2 all flags, none enabled
    11'b000_000_1_0000   // R5 read clears
  };

  string tags [NV] = '{"R2", "R3", "R2 R4", "R3", "R3 R7", "R5",
                        "R6", "R4", "R5", "R2", "R5"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    rst = 1'b1; evt_pulse = '0; evt_en = '0; stat_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset stat", 32'(stat_q), 32'h0);
    chk("R1 reset irq", 32'(irq_drive_low), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    prev = 4'h0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      evt_pulse = VEC[k][10:8];
      evt_en    = VEC[k][7:5];
      stat_rd   = VEC[k][4];
      #1;
      if (stat_rd) chk({tags[k], " R5 pre-read image"}, 32'(stat_q), 32'(prev));
      @(posedge clk);
      #1;
      chk({tags[k], " stat"}, 32'(stat_q), 32'(VEC[k][3:0]));
      chk({tags[k], " R7 irq"}, 32'(irq_drive_low), 32'(VEC[k][3]));
      prev = VEC[k][3:0];
    end

    // R3: a flag with its enable set pulls the line low
    @(negedge clk);
    evt_pulse = 3'b111; evt_en = 3'b111; stat_rd = 1'b0;
    @(posedge clk); #1;
    chk("R3 all enabled irq", 32'(irq_drive_low), 32'h1);

    // R1: reset wins over a pulse arriving at the same edge
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset vs pulse stat", 32'(stat_q), 32'h0);
    chk("R1 reset vs pulse irq", 32'(irq_drive_low), 32'h0);

    // R5: a read with nothing pending leaves everything clear
    @(negedge clk);
    rst = 1'b0; evt_pulse = '0; stat_rd = 1'b1;
    @(posedge clk); #1;
    chk("R5 idle read", 32'(stat_q), 32'h0);
    @(negedge clk);
    stat_rd = 1'b0;

    // R6: a pulse on the periodic flag during a read while alarm is set
    evt_pulse = 3'b001;
    @(negedge clk);
    evt_pulse = 3'b010; stat_rd = 1'b1;
    @(posedge clk); #1;
    chk("R6 collide stat", 32'(stat_q), 32'hA);
    @(negedge clk);
    evt_pulse = '0; stat_rd = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule